// File: doc/BRIEF.md
# I2C Byte-Command Bus Master

This block is a memory-mapped I2C master that moves exactly one byte on the bus for each command written to its control register. Software sets a target address byte and, for a write, a data byte. It then writes a command word with up to three bits set: one opens a transaction, one moves a byte, and one closes the transaction after that byte. The block generates the START condition, the address byte, the data byte with its acknowledge bit, and the STOP condition. It reports the outcome through a fixed status word and a completion interrupt.

SCL and SDA are open-drain. The block drives each line only by pulling it low through an output enable and reads the resolved level back on an input. The clock rate is set by a period register, and each SCL half-period lasts (1 + period) × 10 system clocks. The block supports a single bus master only. If either line is low when a START is requested, the block flags a lost start instead of arbitrating.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset the status word reads 0x20 (only idle set), the raw interrupt and `irq_o` are 0, and neither bus line is pulled low.
- R2: Status bit positions are: 0 busy, 1 error, 2 address NACK, 3 data NACK, 4 lost start, 5 idle, 6 bus owned. While a command sequence is running, busy reads 1 and idle reads 0.
- R3: The configuration register at 0x10 keeps only bits 5, 4 and 0. Commands written to 0x00 while bit 4 of the configuration register is clear produce no bus activity and no status change.
- R4: A command with bit 1 (START) set while the bus is not owned checks both lines. If both are high, the block sends a START, then the address byte (register 0x04: bits 7:1 target, bit 0 = 1 for read). It then sets bus-owned and clears lost-start. If either line is low, the block sets lost-start, drives nothing, and also sets error when RUN was requested. A START issued while the bus is already owned is ignored.
- R5: A command with bit 0 (RUN) set while the bus is not owned after any START sets error and moves no byte. Any other accepted command clears error and both NACK flags.
- R6: In write direction, RUN sends the data register (0x08) MSB first. A NACK from the slave sets data-NACK and error.
- R7: In read direction, RUN shifts a byte into the data register. The block acknowledges the byte with ACK, or with NACK when STOP (bit 2) is part of the same command.
- R8: An address NACK sets address-NACK and error, skips the data byte, sends a STOP, and clears bus-owned.
- R9: STOP (bit 2) sends a STOP condition after the command's byte and clears bus-owned. Without STOP the block keeps SCL low and keeps bus ownership.
- R10: During byte transfers, each SCL high phase lasts (1 + period) × 10 clocks, where period is the value in register 0x0C.
- R11: Raw interrupt bit 0 (0x18) sets when any accepted command finishes. `irq_o` and register 0x1C equal raw AND mask (0x14). Writing 1 to bit 0 of 0x20 clears the raw bit.
- R12: SDA changes while SCL is high only to form START or STOP.
- R13: A command written while busy reads 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | AW | Byte address of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data (combinational) |
| irq_o | output | 1 | Completion interrupt, raw AND mask |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with its default widths (6-bit address, 32-bit data, 8-bit period, factor 10). It runs with a period of 0, giving 10-clock half-periods, so that whole multi-byte transactions, NACK aborts and the lost-start path fit in a few thousand cycles. It then switches to a period of 2, which shows that the half-period follows the register rather than a fixed value.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  // word index of each register (byte address >> 2)
  localparam int unsigned RG_CTRL = 0;
  localparam int unsigned RG_ADDR = 1;
  localparam int unsigned RG_DATA = 2;
  localparam int unsigned RG_TPER = 3;
  localparam int unsigned RG_CFG  = 4;
  localparam int unsigned RG_MASK = 5;
  localparam int unsigned RG_RAW  = 6;
  localparam int unsigned RG_MIS  = 7;
  localparam int unsigned RG_CLR  = 8;

  localparam int unsigned CFG_EN_BIT = 4;
  localparam logic [5:0]  CFG_KEEP   = 6'b110001;

  typedef struct packed {
    logic stop;
    logic start;
    logic run;
  } cmd_t;

  typedef enum logic [2:0] {
    E_IDLE, E_SA, E_SB, E_LO, E_HI, E_PA, E_PB, E_PC
  } eng_state_e;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int unsigned PW   = 8,
  parameter int unsigned UNIT = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          tick_o
);
  localparam int unsigned CW = PW + $clog2(UNIT) + 1;

  logic [CW-1:0] cnt_q, limit;

  assign limit  = (CW'(period_i) + CW'(1)) * CW'(UNIT) - CW'(1);
  assign tick_o = run_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  // R10
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  cmd_t       cmd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       tick_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       active_o,
  output logic       done_o,
  output logic       own_o,
  output logic       err_o,
  output logic       anack_o,
  output logic       dnack_o,
  output logic       arb_o,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  eng_state_e st_q;
  logic [7:0] sh_q, adr_q, wbyte_q, rdata_q;
  logic [3:0] bit_q;
  logic       own_q, is_addr_q, is_rd_q, rd_dir_q, need_run_q, need_stop_q;
  logic       done_q, err_q, anack_q, dnack_q, arb_q, rvalid_q;
  logic       data_rx, bit_low;

  assign data_rx = is_rd_q && !is_addr_q;
  // ack slot: receiver-side ack for reads, released otherwise
  assign bit_low = (bit_q < 4'd8) ? (!data_rx && !sh_q[7]) : (data_rx && !need_stop_q);

  always_comb begin
    unique case (st_q)
      E_IDLE:       begin scl_oe_o = own_q; sda_oe_o = 1'b0;    end
      E_SA:         begin scl_oe_o = 1'b0;  sda_oe_o = 1'b0;    end
      E_SB:         begin scl_oe_o = 1'b0;  sda_oe_o = 1'b1;    end
      E_LO:         begin scl_oe_o = 1'b1;  sda_oe_o = bit_low; end
      E_HI:         begin scl_oe_o = 1'b0;  sda_oe_o = bit_low; end
      E_PA:         begin scl_oe_o = 1'b1;  sda_oe_o = 1'b1;    end
      E_PB:         begin scl_oe_o = 1'b0;  sda_oe_o = 1'b1;    end
      default:      begin scl_oe_o = 1'b0;  sda_oe_o = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE;
      sh_q <= '0; adr_q <= '0; wbyte_q <= '0; rdata_q <= '0; bit_q <= '0;
      own_q <= 1'b0; is_addr_q <= 1'b0; is_rd_q <= 1'b0; rd_dir_q <= 1'b0;
      need_run_q <= 1'b0; need_stop_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; anack_q <= 1'b0; dnack_q <= 1'b0;
      arb_q <= 1'b0; rvalid_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      unique case (st_q)
        E_IDLE: if (go_i) begin
          err_q <= 1'b0; anack_q <= 1'b0; dnack_q <= 1'b0;
          need_run_q <= cmd_i.run; need_stop_q <= cmd_i.stop;
          adr_q <= addr_i; wbyte_q <= wdata_i; rd_dir_q <= addr_i[0];
          if (cmd_i.start && !own_q) begin
            if (scl_i && sda_i) begin
              arb_q <= 1'b0;
              st_q  <= E_SA;
            end else begin
              arb_q  <= 1'b1;
              err_q  <= cmd_i.run;
              done_q <= 1'b1;
            end
          end else if (!own_q) begin
            err_q  <= cmd_i.run;
            done_q <= 1'b1;
          end else if (cmd_i.run) begin
            is_addr_q <= 1'b0; is_rd_q <= addr_i[0]; sh_q <= wdata_i; bit_q <= '0;
            st_q <= E_LO;
          end else if (cmd_i.stop) begin
            st_q <= E_PA;
          end else begin
            done_q <= 1'b1;
          end
        end
        E_SA: if (tick_i) st_q <= E_SB;
        E_SB: if (tick_i) begin
          own_q <= 1'b1; sh_q <= adr_q; is_addr_q <= 1'b1; is_rd_q <= 1'b0; bit_q <= '0;
          st_q  <= E_LO;
        end
        E_LO: if (tick_i) st_q <= E_HI;
        E_HI: if (tick_i) begin
          if (bit_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_i};
            bit_q <= bit_q + 4'd1;
            st_q  <= E_LO;
          end else if (is_addr_q) begin
            if (sda_i) begin
              anack_q <= 1'b1; err_q <= 1'b1;
              st_q    <= E_PA;
            end else if (need_run_q) begin
              is_addr_q <= 1'b0; is_rd_q <= rd_dir_q; sh_q <= wbyte_q; bit_q <= '0;
              st_q <= E_LO;
            end else if (need_stop_q) begin
              st_q <= E_PA;
            end else begin
              st_q <= E_IDLE; done_q <= 1'b1;
            end
          end else begin
            if (is_rd_q) begin
              rdata_q <= sh_q; rvalid_q <= 1'b1;
            end else if (sda_i) begin
              dnack_q <= 1'b1; err_q <= 1'b1;
            end
            if (need_stop_q) st_q <= E_PA;
            else begin st_q <= E_IDLE; done_q <= 1'b1; end
          end
        end
        E_PA: if (tick_i) st_q <= E_PB;
        E_PB: if (tick_i) st_q <= E_PC;
        E_PC: if (tick_i) begin
          own_q <= 1'b0; st_q <= E_IDLE; done_q <= 1'b1;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign active_o = (st_q != E_IDLE);
  assign done_o   = done_q;
  assign own_o    = own_q;
  assign err_o    = err_q;
  assign anack_o  = anack_q;
  assign dnack_o  = dnack_q;
  assign arb_o    = arb_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R12
  sda_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && (st_q == E_LO || st_q == E_HI)) |-> scl_oe_o);

  // R9
  own_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(own_q) |-> ($past(st_q) == E_PC && st_q == E_IDLE));

  // R5
  run_no_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && st_q == E_IDLE && !own_q && cmd_i.run && !cmd_i.start) |=> (err_q && st_q == E_IDLE && done_q));

  // R8
  anack_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(anack_q) |-> (st_q == E_PA));

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int unsigned AW   = 6,
  parameter int unsigned DW   = 32,
  parameter int unsigned PW   = 8,
  parameter int unsigned UNIT = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  localparam int unsigned WW = AW - 2;

  logic [WW-1:0] widx;
  logic [7:0]    sa_q, dat_q;
  logic [PW-1:0] tp_q;
  logic [5:0]    cfg_q;
  logic          mask_q, raw_q;
  logic          wr, cmd_wr, go, tick;
  logic          e_active, e_done, e_own, e_err, e_anack, e_dnack, e_arb, e_rvalid;
  logic [7:0]    e_rdata;
  logic [6:0]    status;
  cmd_t          cmd;

  assign widx   = addr_i[AW-1:2];
  assign wr     = sel_i && we_i;
  assign cmd_wr = wr && (widx == WW'(RG_CTRL));
  assign go     = cmd_wr && cfg_q[CFG_EN_BIT] && !e_active;
  assign cmd    = cmd_t'(wdata_i[2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q <= '0; dat_q <= '0; tp_q <= '0; cfg_q <= '0; mask_q <= 1'b0; raw_q <= 1'b0;
    end else begin
      if (wr && widx == WW'(RG_ADDR)) sa_q   <= wdata_i[7:0];
      if (wr && widx == WW'(RG_TPER)) tp_q   <= wdata_i[PW-1:0];
      if (wr && widx == WW'(RG_CFG))  cfg_q  <= wdata_i[5:0] & CFG_KEEP;
      if (wr && widx == WW'(RG_MASK)) mask_q <= wdata_i[0];
      if (e_rvalid)                              dat_q <= e_rdata;
      else if (wr && widx == WW'(RG_DATA))       dat_q <= wdata_i[7:0];
      if (e_done)                                raw_q <= 1'b1;
      else if (wr && widx == WW'(RG_CLR) && wdata_i[0]) raw_q <= 1'b0;
    end
  end

  i2cm_tick #(.PW(PW), .UNIT(UNIT)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (e_active),
    .period_i (tp_q),
    .tick_o   (tick)
  );

  i2cm_engine u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .cmd_i    (cmd),
    .addr_i   (sa_q),
    .wdata_i  (dat_q),
    .tick_i   (tick),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .active_o (e_active),
    .done_o   (e_done),
    .own_o    (e_own),
    .err_o    (e_err),
    .anack_o  (e_anack),
    .dnack_o  (e_dnack),
    .arb_o    (e_arb),
    .rdata_o  (e_rdata),
    .rvalid_o (e_rvalid)
  );

  assign status = {e_own, !e_active, e_arb, e_dnack, e_anack, e_err, e_active};
  assign irq_o  = raw_q && mask_q;

  always_comb begin
    rdata_o = '0;
    unique case (widx)
      WW'(RG_CTRL): rdata_o = DW'(status);
      WW'(RG_ADDR): rdata_o = DW'(sa_q);
      WW'(RG_DATA): rdata_o = DW'(dat_q);
      WW'(RG_TPER): rdata_o = DW'(tp_q);
      WW'(RG_CFG):  rdata_o = DW'(cfg_q);
      WW'(RG_MASK): rdata_o = DW'(mask_q);
      WW'(RG_RAW):  rdata_o = DW'(raw_q);
      WW'(RG_MIS):  rdata_o = DW'(raw_q && mask_q);
      default:      rdata_o = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  // R3
  cmd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !cfg_q[CFG_EN_BIT] && !e_active) |=> !e_active);

  // R13
  cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && e_active) |=> (e_active || e_done));

  // R11
  raw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> $past(e_done));

endmodule

// File: tb/i2cm_ctrl_tb.sv
module i2cm_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, scl_oe, sda_oe;
  logic        tb_scl_hold = 1'b0;
  logic        sl_low = 1'b0;
  logic        scl_line, sda_line;

  assign scl_line = !scl_oe && !tb_scl_hold;
  assign sda_line = !sda_oe && !sl_low;

  i2cm_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output int v);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 v = int'(rdata);
    sel = 1'b0;
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 20000; i++) begin
      rd(6'h00, v);
      if ((v & 1) == 0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_cmd(int c);
    wr(6'h00, c);
    wait_idle();
  endtask

  // behavioural slave at address 0x3A
  localparam logic [6:0] SLV = 7'h3A;
  logic       act = 0, aph = 0, tx = 0, match = 0, rw = 0, mack = 0, nack_mode = 0;
  int         bitn = 0;
  logic [7:0] sh = 0, txb = 0;
  logic [7:0] rx_log[$];
  logic [7:0] tx_src[$];
  int         start_cnt = 0, stop_cnt = 0;
  logic       p_scl = 1, p_sda = 1;

  // SCL timing monitor
  int exp_half = 10, hi_len = 0, lo_len = 0, last_lo = 0, measured = 0, mism = 0;
  bit sda_moved = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      // timing monitor, every clock
      if (scl_line && !p_scl) begin
        last_lo = lo_len; hi_len = 1; sda_moved = 0;
      end else if (scl_line) begin
        hi_len++;
        if (sda_line != p_sda) sda_moved = 1;
      end else if (!scl_line && p_scl) begin
        if (last_lo == exp_half && !sda_moved) begin
          measured++;
          if (hi_len != exp_half) mism++;
        end
        lo_len = 1;
      end else lo_len++;

      // slave protocol
      if (p_scl && scl_line && p_sda && !sda_line) begin
        act = 1; aph = 1; bitn = 0; tx = 0; match = 0; sl_low = 0; start_cnt++;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        act = 0; sl_low = 0; stop_cnt++;
      end else if (act && !p_scl && scl_line) begin
        if (bitn < 8 && !tx) sh = {sh[6:0], sda_line};
        if (bitn == 8 && tx) mack = !sda_line;
        bitn++;
      end else if (act && p_scl && !scl_line) begin
        if (bitn == 8) begin
          if (aph) begin
            match = (sh[7:1] == SLV); rw = sh[0]; sl_low = match;
          end else if (!tx) begin
            if (match) rx_log.push_back(sh);
            sl_low = match && !nack_mode;
          end else sl_low = 0;
        end else if (bitn == 9) begin
          bitn = 0;
          if (aph) begin
            aph = 0;
            if (match && rw) begin
              tx = 1; txb = (tx_src.size() > 0) ? tx_src.pop_front() : 8'hFF; sl_low = !txb[7];
            end else sl_low = 0;
          end else if (tx) begin
            if (mack) begin
              txb = (tx_src.size() > 0) ? tx_src.pop_front() : 8'hFF; sl_low = !txb[7];
            end else begin tx = 0; sl_low = 0; end
          end else sl_low = 0;
        end else if (bitn >= 1 && bitn <= 7 && tx) begin
          sl_low = !txb[7 - bitn];
        end
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  function automatic int rx_pop();
    if (rx_log.size() == 0) return -1;
    return int'(rx_log.pop_front());
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1
    rd(6'h00, v); chk("R1 status", v, 32'h20);
    chk("R1 irq", int'(irq), 0);
    rd(6'h18, v); chk("R1 raw", v, 0);
    chk("R1 lines", int'({scl_line, sda_line}), 3);

    // R3 enable gating and config masking
    wr(6'h10, 32'h0E); rd(6'h10, v); chk("R3 cfg keep", v, 0);
    wr(6'h00, 32'h3);
    repeat (50) @(negedge clk);
    rd(6'h00, v); chk("R3 disabled cmd status", v, 32'h20);
    chk("R3 disabled no start", start_cnt, 0);
    wr(6'h10, 32'hFF); rd(6'h10, v); chk("R3 cfg readback", v, 32'h31);
    wr(6'h14, 32'h1);

    // R2 / R4 / R6 write with start
    wr(6'h04, 32'h74); wr(6'h08, 32'hA5);
    wr(6'h00, 32'h3);
    repeat (40) @(negedge clk);
    rd(6'h00, v); chk("R2 busy status", v, 32'h41);
    wait_idle();
    rd(6'h00, v); chk("R4 owned idle status", v, 32'h60);
    chk("R6 byte sent", rx_pop(), 32'hA5);
    chk("R11 irq set", int'(irq), 1);
    rd(6'h1C, v); chk("R11 masked", v, 1);
    wr(6'h20, 32'h1);
    @(negedge clk); chk("R11 irq cleared", int'(irq), 0);

    // R9 held bus, then byte with stop
    wr(6'h08, 32'h3C); do_cmd(32'h1);
    rd(6'h00, v); chk("R9 held status", v, 32'h60);
    chk("R9 held scl low", int'(scl_line), 0);
    chk("R6 second byte", rx_pop(), 32'h3C);
    chk("R12 one start", start_cnt, 1);
    wr(6'h08, 32'h81); do_cmd(32'h5);
    rd(6'h00, v); chk("R9 stop status", v, 32'h20);
    chk("R6 third byte", rx_pop(), 32'h81);
    chk("R9 stop seen", stop_cnt, 1);

    // R5 run without ownership
    wr(6'h20, 32'h1);
    do_cmd(32'h1);
    rd(6'h00, v); chk("R5 error status", v, 32'h22);
    chk("R5 no start", start_cnt, 1);
    chk("R5 nothing sent", int'(rx_log.size()), 0);
    rd(6'h18, v); chk("R11 raw on error", v, 1);

    // R6 data NACK
    nack_mode = 1;
    wr(6'h08, 32'h55); do_cmd(32'h7);
    rd(6'h00, v); chk("R6 data nack status", v, 32'h2A);
    chk("R9 stop after nack", stop_cnt, 2);
    nack_mode = 0; rx_log.delete();

    // R8 address NACK
    wr(6'h04, 32'h22); do_cmd(32'h3);
    rd(6'h00, v); chk("R8 addr nack status", v, 32'h26);
    chk("R8 stop sent", stop_cnt, 3);
    chk("R8 no data", int'(rx_log.size()), 0);

    // R7 reads
    tx_src.push_back(8'hC3); tx_src.push_back(8'h5E);
    wr(6'h04, 32'h75); do_cmd(32'h3);
    rd(6'h00, v); chk("R7 read status", v, 32'h60);
    rd(6'h08, v); chk("R7 first byte", v, 32'hC3);
    chk("R7 master ack", int'(mack), 1);
    do_cmd(32'h5);
    rd(6'h08, v); chk("R7 last byte", v, 32'h5E);
    chk("R7 master nack", int'(mack), 0);
    rd(6'h00, v); chk("R7 final status", v, 32'h20);

    // R4 lost start, then recovery
    tb_scl_hold = 1;
    do_cmd(32'h3);
    rd(6'h00, v); chk("R4 lost start status", v, 32'h32);
    chk("R4 no start driven", start_cnt, 4);
    tb_scl_hold = 0;
    repeat (5) @(negedge clk);
    wr(6'h04, 32'h74); do_cmd(32'h6);
    rd(6'h00, v); chk("R4 arb cleared", v, 32'h20);
    chk("R4 start count", start_cnt, 5);

    // R13 command while busy
    wr(6'h08, 32'h99);
    wr(6'h00, 32'h3);
    wr(6'h00, 32'h4);
    wait_idle();
    rd(6'h00, v); chk("R13 stop ignored", v, 32'h60);
    chk("R13 byte sent", rx_pop(), 32'h99);
    chk("R13 no stop", stop_cnt, 5);
    do_cmd(32'h4);
    rd(6'h00, v); chk("R9 stop only", v, 32'h20);

    // R10 timing, period 0 then 2
    chk("R10 measured p0", int'(measured > 0), 1);
    chk("R10 high phase p0", mism, 0);
    wr(6'h0C, 32'h2);
    exp_half = 30; measured = 0; mism = 0;
    wr(6'h08, 32'h0F); do_cmd(32'h7);
    rd(6'h00, v); chk("R10 status", v, 32'h20);
    chk("R10 byte", rx_pop(), 32'h0F);
    chk("R10 measured p2", int'(measured > 0), 1);
    chk("R10 high phase p2", mism, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule